// File: doc/BRIEF.md
# Message Interrupt Vector Table with Pending Bits

This block stores a parameterised set of message-signalled interrupt vectors. Each vector holds a 64-bit target address, a 32-bit payload word and a mask flag. When a function raises an interrupt request for one of its vectors, the block either emits one memory-write message built from that vector's address and payload, or records the request in a packed pending array if the vector is masked or the output is busy. Recorded requests are replayed without software help once the vector becomes deliverable.

Software reaches the table through a 32-bit read/write register port and can inspect the pending array through a separate read-only port. The function mask is a level input from the surrounding capability logic. A rescan strobe tells the block that the function mask has changed, and it then drains every deliverable pending vector in ascending order. Messages leave through a single valid/ready interface, one at a time.

Top module: `msgirq_vector_unit`

## Requirements
- R1: Each vector occupies 16 bytes of table space at byte offset 16*v: offset 0 holds address bits 31:0, offset 4 holds address bits 63:32, offset 8 holds the payload, and offset 12 is a control word whose bit 0 is the mask flag, with all other control bits reading as zero. A table read returns its data one clock after the access.
- R2: Table and pending accesses take effect only with all four byte enables set (4'hF) and a dword-aligned address. Any other access leaves the table unchanged on a write and returns zero on a read.
- R3: A vector is masked whenever the function mask input is high or its own mask flag is set, and no message is ever sent for a vector that is masked in the cycle it is chosen.
- R4: A request for a masked vector sets that vector's pending bit and sends no message.
- R5: A request for an unmasked vector while the output slot is free sends exactly one message carrying that vector's address and payload, valid from the clock edge that samples the request.
- R6: A request whose vector number is equal to or above the number of vectors, or whose in-use bit is low, changes neither the pending array nor the output.
- R7: A table write that clears the mask flag of a vector with a pending bit set clears that bit and sends the vector's message.
- R8: A rescan strobe sends every pending vector that is not masked, one message per completed handshake, in ascending vector order, and clears their pending bits.
- R9: A function-mask drop without a rescan strobe sends nothing; pending vectors stay pending.
- R10: Pending bit v is bit (v mod 32) of pending dword (v div 32), so byte (v div 8) bit (v mod 8) in little-endian order; the pending array spans a whole multiple of 64 vectors and bits beyond the last vector read as zero.
- R11: While a message is valid and not accepted, its address and payload stay unchanged; a request that cannot be sent because the slot is occupied is recorded as pending and sent after the slot frees.
- R12: A replay chosen from the pending array takes the output slot ahead of a fresh request in the same cycle; the fresh request is recorded as pending and follows.
- R13: Reset clears all addresses, payloads and pending bits, sets every mask flag, and drops the message valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_en | input | 1 | Table access strobe |
| tbl_we | input | 1 | Table access is a write |
| tbl_addr | input | TA_W | Table byte address |
| tbl_be | input | 4 | Table byte enables |
| tbl_wdata | input | 32 | Table write data |
| tbl_rdata | output | 32 | Table read data, one cycle after the access |
| pnd_en | input | 1 | Pending-array read strobe |
| pnd_idx | input | PW_W | Pending dword index |
| pnd_be | input | 4 | Pending read byte enables |
| pnd_rdata | output | 32 | Pending read data, one cycle after the access |
| irq_stb | input | 1 | Interrupt request strobe |
| irq_vec | input | REQ_W | Requested vector number |
| vec_used | input | NUM_VEC | Per-vector in-use flags |
| fn_mask | input | 1 | Function-wide mask level |
| rescan | input | 1 | Drain pending vectors after a function-mask change |
| msg_valid | output | 1 | Outgoing message valid |
| msg_ready | input | 1 | Outgoing message accepted |
| msg_addr | output | 64 | Message target address |
| msg_data | output | 32 | Message payload |

## Verification
The two functions that meet in one cycle are the pending-array replay and a fresh request, both competing for the single output slot. The bench unmasks a pending vector through a table write and raises a request for another, already unmasked vector on the very next clock, which is the edge at which the replay is chosen. The scoreboard then demands the replayed vector's message first and the fresh request's message second, so a design that lets the request win, or drops it, reports a mismatch or a leftover expectation.

// File: rtl/msgirq_pkg.sv
package msgirq_pkg;

   // One outgoing memory-write message
   typedef struct packed {
      logic [63:0] addr;
      logic [31:0] data;
   } msg_t;

   // Dword slots inside one 16-byte vector entry
   typedef enum logic [1:0] {
      W_ADDR_LO = 2'd0,
      W_ADDR_HI = 2'd1,
      W_DATA    = 2'd2,
      W_CTRL    = 2'd3
   } entry_word_e;

endpackage

// File: rtl/msgirq_entry_store.sv
module msgirq_entry_store
   import msgirq_pkg::*;
#(
   parameter int NUM_VEC = 8,
   localparam int VI_W = $clog2(NUM_VEC),
   localparam int TA_W = VI_W + 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic               rd_en,
   input  logic               acc_ok,
   input  logic [TA_W-1:0]    acc_addr,
   input  logic [31:0]        wr_data,
   output logic [31:0]        rd_data,
   output logic [NUM_VEC-1:0] mask_vec,
   output logic [NUM_VEC-1:0] unmask_evt,
   input  logic [VI_W-1:0]    sel_idx,
   output msg_t               sel_msg
);

   logic [31:0] lo_q  [NUM_VEC];
   logic [31:0] hi_q  [NUM_VEC];
   logic [31:0] dat_q [NUM_VEC];
   logic [NUM_VEC-1:0] msk_q;

   logic [VI_W-1:0] acc_vec;
   entry_word_e     acc_word;
   logic            acc_hit;

   assign acc_vec  = acc_addr[TA_W-1:4];
   assign acc_word = entry_word_e'(acc_addr[3:2]);
   assign acc_hit  = acc_ok && (int'(acc_vec) < NUM_VEC);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int v = 0; v < NUM_VEC; v++) begin
            lo_q[v]  <= '0;
            hi_q[v]  <= '0;
            dat_q[v] <= '0;
         end
         msk_q <= '1;
      end else if (wr_en && acc_hit) begin
         unique case (acc_word)
            W_ADDR_LO: lo_q[acc_vec]  <= wr_data;
            W_ADDR_HI: hi_q[acc_vec]  <= wr_data;
            W_DATA:    dat_q[acc_vec] <= wr_data;
            W_CTRL:    msk_q[acc_vec] <= wr_data[0];
            default: ;
         endcase
      end
   end

   always_comb begin
      unmask_evt = '0;
      if (wr_en && acc_hit && acc_word == W_CTRL && msk_q[acc_vec] && !wr_data[0])
         unmask_evt[acc_vec] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_data <= '0;
      end else if (rd_en) begin
         if (!acc_hit) begin
            rd_data <= '0;
         end else begin
            unique case (acc_word)
               W_ADDR_LO: rd_data <= lo_q[acc_vec];
               W_ADDR_HI: rd_data <= hi_q[acc_vec];
               W_DATA:    rd_data <= dat_q[acc_vec];
               W_CTRL:    rd_data <= {31'd0, msk_q[acc_vec]};
               default:   rd_data <= '0;
            endcase
         end
      end
   end

   assign mask_vec     = msk_q;
   assign sel_msg.addr = {hi_q[sel_idx], lo_q[sel_idx]};
   assign sel_msg.data = dat_q[sel_idx];

   // R1: a control-word write lands in the mask flag seen by the rest of the block
   a_r1_ctrl_write: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && acc_hit && acc_word == W_CTRL)
      |=> (mask_vec[$past(acc_vec)] == $past(wr_data[0])));

endmodule

// File: rtl/msgirq_pend_ctl.sv
module msgirq_pend_ctl #(
   parameter int NUM_VEC = 8,
   localparam int VI_W     = $clog2(NUM_VEC),
   localparam int PBA_BITS = ((NUM_VEC + 63) / 64) * 64,
   localparam int PBA_DW   = PBA_BITS / 32,
   localparam int PW_W     = $clog2(PBA_DW)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_VEC-1:0] set_pend,
   input  logic [NUM_VEC-1:0] set_cand,
   input  logic               rescan,
   input  logic [NUM_VEC-1:0] unmasked,
   input  logic               allow,
   output logic               grant_vld,
   output logic [VI_W-1:0]    grant_idx,
   output logic [NUM_VEC-1:0] pend_vec,
   input  logic               rd_en,
   input  logic               rd_ok,
   input  logic [PW_W-1:0]    rd_idx,
   output logic [31:0]        rd_data
);

   logic [NUM_VEC-1:0]  pend_q, cand_q;
   logic [NUM_VEC-1:0]  elig, pick, grant_oh;
   logic [PBA_BITS-1:0] pend_pad;

   assign elig = cand_q & pend_q & unmasked;
   assign pick = allow ? elig : '0;

   // lowest-numbered eligible vector wins
   always_comb begin
      grant_vld = 1'b0;
      grant_idx = '0;
      for (int i = NUM_VEC - 1; i >= 0; i--) begin
         if (pick[i]) begin
            grant_vld = 1'b1;
            grant_idx = VI_W'(i);
         end
      end
   end

   assign grant_oh = grant_vld ? (NUM_VEC'(1) << grant_idx) : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= '0;
         cand_q <= '0;
      end else begin
         pend_q <= (pend_q & ~grant_oh) | set_pend;
         cand_q <= (elig & ~grant_oh) | set_cand | {NUM_VEC{rescan}};
      end
   end

   generate
      if (PBA_BITS > NUM_VEC) begin : g_pad
         assign pend_pad = {{(PBA_BITS - NUM_VEC){1'b0}}, pend_q};
      end else begin : g_full
         assign pend_pad = pend_q;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)     rd_data <= '0;
      else if (rd_en) rd_data <= rd_ok ? pend_pad[rd_idx*32 +: 32] : 32'd0;
   end

   assign pend_vec = pend_q;

   // R7/R8: a chosen vector leaves the pending array at the next edge unless re-requested
   a_r8_grant_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_vld && !set_pend[grant_idx]) |=> !pend_vec[$past(grant_idx)]);

endmodule

// File: rtl/msgirq_msg_slot.sv
module msgirq_msg_slot
   import msgirq_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  load,
   input  msg_t  msg_in,
   output logic  free,
   output logic  valid,
   input  logic  ready,
   output msg_t  msg_out
);

   assign free = !valid || ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid   <= 1'b0;
         msg_out <= '0;
      end else if (load) begin
         valid   <= 1'b1;
         msg_out <= msg_in;
      end else if (ready) begin
         valid   <= 1'b0;
      end
   end

   // R11: a stalled message is held unchanged
   a_r11_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && !ready) |=> (valid && $stable(msg_out)));

endmodule

// File: rtl/msgirq_vector_unit.sv
module msgirq_vector_unit
   import msgirq_pkg::*;
#(
   parameter int NUM_VEC = 8,
   localparam int VI_W     = $clog2(NUM_VEC),
   localparam int REQ_W    = VI_W + 1,
   localparam int TA_W     = VI_W + 4,
   localparam int PBA_DW   = ((NUM_VEC + 63) / 64) * 2,
   localparam int PW_W     = $clog2(PBA_DW)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tbl_en,
   input  logic               tbl_we,
   input  logic [TA_W-1:0]    tbl_addr,
   input  logic [3:0]         tbl_be,
   input  logic [31:0]        tbl_wdata,
   output logic [31:0]        tbl_rdata,
   input  logic               pnd_en,
   input  logic [PW_W-1:0]    pnd_idx,
   input  logic [3:0]         pnd_be,
   output logic [31:0]        pnd_rdata,
   input  logic               irq_stb,
   input  logic [REQ_W-1:0]   irq_vec,
   input  logic [NUM_VEC-1:0] vec_used,
   input  logic               fn_mask,
   input  logic               rescan,
   output logic               msg_valid,
   input  logic               msg_ready,
   output logic [63:0]        msg_addr,
   output logic [31:0]        msg_data
);

   initial begin
      assert (NUM_VEC >= 2 && NUM_VEC <= 2048)
         else $error("NUM_VEC must lie in 2..2048");
   end

   logic [NUM_VEC-1:0] mask_vec, masked, unmask_evt, pend_vec;
   logic [NUM_VEC-1:0] set_pend, set_cand, req_oh;
   logic               tbl_ok, req_ok, direct, load, slot_free, grant_vld;
   logic [VI_W-1:0]    req_idx, grant_idx, load_idx;
   msg_t               sel_msg, out_msg;

   assign tbl_ok = (tbl_be == 4'hF) && (tbl_addr[1:0] == 2'b00);
   assign masked = mask_vec | {NUM_VEC{fn_mask}};

   assign req_idx = irq_vec[VI_W-1:0];
   assign req_ok  = irq_stb && (int'(irq_vec) < NUM_VEC) && vec_used[req_idx];
   assign req_oh  = req_ok ? (NUM_VEC'(1) << req_idx) : '0;

   // replay has priority for the slot; a fresh request only uses it when left free
   assign direct   = req_ok && !masked[req_idx] && slot_free && !grant_vld;
   assign set_pend = direct ? '0 : req_oh;
   assign set_cand = unmask_evt | ((req_ok && !masked[req_idx] && !direct) ? req_oh : '0);

   assign load     = grant_vld || direct;
   assign load_idx = grant_vld ? grant_idx : req_idx;

   msgirq_entry_store #(.NUM_VEC(NUM_VEC)) u_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (tbl_en && tbl_we),
      .rd_en      (tbl_en && !tbl_we),
      .acc_ok     (tbl_ok),
      .acc_addr   (tbl_addr),
      .wr_data    (tbl_wdata),
      .rd_data    (tbl_rdata),
      .mask_vec   (mask_vec),
      .unmask_evt (unmask_evt),
      .sel_idx    (load_idx),
      .sel_msg    (sel_msg)
   );

   msgirq_pend_ctl #(.NUM_VEC(NUM_VEC)) u_pend (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_pend  (set_pend),
      .set_cand  (set_cand),
      .rescan    (rescan),
      .unmasked  (~masked),
      .allow     (slot_free),
      .grant_vld (grant_vld),
      .grant_idx (grant_idx),
      .pend_vec  (pend_vec),
      .rd_en     (pnd_en),
      .rd_ok     (pnd_be == 4'hF),
      .rd_idx    (pnd_idx),
      .rd_data   (pnd_rdata)
   );

   msgirq_msg_slot u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (load),
      .msg_in  (sel_msg),
      .free    (slot_free),
      .valid   (msg_valid),
      .ready   (msg_ready),
      .msg_out (out_msg)
   );

   assign msg_addr = out_msg.addr;
   assign msg_data = out_msg.data;

   // R3: nothing masked is ever loaded into the output slot
   a_r3_no_masked_send: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> !masked[load_idx]);

   // R4: a masked request shows up in the pending array on the next cycle
   a_r4_masked_pends: assert property (@(posedge clk) disable iff (!rst_n)
      (req_ok && masked[req_idx]) |=> pend_vec[$past(req_idx)]);

   // R6: an out-of-range request never produces a message by itself
   a_r6_range_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_stb && int'(irq_vec) >= NUM_VEC && !grant_vld && !(msg_valid && !msg_ready))
      |=> !msg_valid);

endmodule

// File: tb/msgirq_vector_unit_tb_top.sv
module msgirq_vector_unit_tb_top;
   timeunit 1ns;
   timeprecision 100ps;

   localparam int NV = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tbl_en = 0, tbl_we = 0;
   logic [6:0]  tbl_addr = '0;
   logic [3:0]  tbl_be = '0;
   logic [31:0] tbl_wdata = '0, tbl_rdata;
   logic        pnd_en = 0;
   logic [0:0]  pnd_idx = '0;
   logic [3:0]  pnd_be = '0;
   logic [31:0] pnd_rdata;
   logic        irq_stb = 0;
   logic [3:0]  irq_vec = '0;
   logic [NV-1:0] vec_used = '0;
   logic        fn_mask = 1'b1, rescan = 0;
   logic        msg_valid, msg_ready = 1'b1;
   logic [63:0] msg_addr;
   logic [31:0] msg_data;

   int n_run = 0, n_fail = 0;
   logic [95:0] exp_q[$];

   always #2.5 clk = ~clk;

   msgirq_vector_unit #(.NUM_VEC(NV)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .tbl_en(tbl_en), .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_be(tbl_be),
      .tbl_wdata(tbl_wdata), .tbl_rdata(tbl_rdata),
      .pnd_en(pnd_en), .pnd_idx(pnd_idx), .pnd_be(pnd_be), .pnd_rdata(pnd_rdata),
      .irq_stb(irq_stb), .irq_vec(irq_vec), .vec_used(vec_used),
      .fn_mask(fn_mask), .rescan(rescan),
      .msg_valid(msg_valid), .msg_ready(msg_ready),
      .msg_addr(msg_addr), .msg_data(msg_data)
   );

   function automatic logic [63:0] ent_addr(int v);
      return 64'hFEE0_0000_0000_1000 + 64'(v) * 64'd16;
   endfunction
   function automatic logic [31:0] ent_data(int v);
      return 32'hC0DE_0000 + 32'(v);
   endfunction

   task automatic chk(bit ok, string tag, logic [95:0] act, logic [95:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   // scoreboard monitor: every accepted message must match the oldest expectation
   always @(negedge clk) begin
      if (rst_n && msg_valid && msg_ready) begin
         if (exp_q.size() == 0) begin
            chk(0, "R3/R6/R9 unexpected message", {msg_addr, msg_data}, '0);
         end else begin
            logic [95:0] e;
            e = exp_q.pop_front();
            chk({msg_addr, msg_data} == e, "R5/R7/R8 message content/order",
                {msg_addr, msg_data}, e);
         end
      end
   end

   task automatic expect_msg(int v);
      exp_q.push_back({ent_addr(v), ent_data(v)});
   endtask

   // all drive tasks start just after a rising edge and end just after the next
   task automatic tbl_wr(int v, int w, logic [31:0] d, logic [3:0] be = 4'hF);
      tbl_en = 1; tbl_we = 1; tbl_addr = 7'(v * 16 + w * 4); tbl_be = be; tbl_wdata = d;
      @(posedge clk); #1;
      tbl_en = 0; tbl_we = 0;
   endtask

   task automatic tbl_rd(int v, int w, output logic [31:0] d, input logic [3:0] be = 4'hF);
      tbl_en = 1; tbl_we = 0; tbl_addr = 7'(v * 16 + w * 4); tbl_be = be;
      @(posedge clk); #1;
      tbl_en = 0;
      d = tbl_rdata;
   endtask

   task automatic pnd_rd(int i, output logic [31:0] d, input logic [3:0] be = 4'hF);
      pnd_en = 1; pnd_idx = 1'(i); pnd_be = be;
      @(posedge clk); #1;
      pnd_en = 0;
      d = pnd_rdata;
   endtask

   task automatic req(int v);
      irq_stb = 1; irq_vec = 4'(v);
      @(posedge clk); #1;
      irq_stb = 0;
   endtask

   task automatic idle(int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic drain(string tag);
      for (int i = 0; i < 40 && exp_q.size() != 0; i++) idle(1);
      idle(2);
      chk(exp_q.size() == 0, tag, 96'(exp_q.size()), 96'd0);
   endtask

   initial begin
      #(150000 * 5);
      chk(0, "watchdog expired", 0, 0);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      logic [31:0] d;
      idle(3);
      rst_n = 1;
      idle(1);

      // R13: reset state
      chk(msg_valid == 0, "R13 valid after reset", 96'(msg_valid), 0);
      tbl_rd(5, 0, d);  chk(d == 0, "R13 address cleared", 96'(d), 0);
      tbl_rd(3, 3, d);  chk(d == 1, "R13 mask flag set", 96'(d), 1);
      pnd_rd(0, d);     chk(d == 0, "R13 pending cleared", 96'(d), 0);

      // R1: program entries, read back layout
      for (int v = 0; v < NV; v++) begin
         logic [63:0] a;
         a = ent_addr(v);
         tbl_wr(v, 0, a[31:0]);
         tbl_wr(v, 1, a[63:32]);
         tbl_wr(v, 2, ent_data(v));
      end
      tbl_rd(2, 2, d);  chk(d == ent_data(2), "R1 payload at offset 8", 96'(d), 96'(ent_data(2)));
      tbl_rd(6, 1, d);  chk(d == 32'hFEE0_0000, "R1 high address at offset 4", 96'(d), 96'hFEE0_0000);
      tbl_wr(4, 3, 32'hFFFF_FFFF);
      tbl_rd(4, 3, d);  chk(d == 1, "R1 control reserved bits zero", 96'(d), 1);

      // R2: partial-width write ignored, partial read returns zero
      tbl_wr(1, 2, 32'h1234_5678, 4'h3);
      tbl_rd(1, 2, d);  chk(d == ent_data(1), "R2 narrow write ignored", 96'(d), 96'(ent_data(1)));
      tbl_rd(1, 2, d, 4'h3); chk(d == 0, "R2 narrow read zero", 96'(d), 0);
      pnd_rd(0, d, 4'h1);    chk(d == 0, "R2 narrow pending read zero", 96'(d), 0);

      vec_used = 8'b0111_1111;
      fn_mask = 0;
      idle(1);

      // R4: masked request goes pending only
      req(2);
      idle(3);
      pnd_rd(0, d);     chk(d == 32'h4, "R4 pending bit 2", 96'(d), 4);

      // R7: unmask through table write replays it
      expect_msg(2);
      tbl_wr(2, 3, 0);
      drain("R7 replay after unmask");
      pnd_rd(0, d);     chk(d == 0, "R7 pending cleared", 96'(d), 0);

      // R5: unmasked request sends directly
      expect_msg(2);
      req(2);
      drain("R5 direct send");

      // R6: out-of-range and unused vectors are ignored
      req(9);
      req(7);
      idle(4);
      pnd_rd(0, d);     chk(d == 0, "R6 ignored requests leave pending", 96'(d), 0);
      chk(msg_valid == 0, "R6 no message", 96'(msg_valid), 0);

      // R3/R9/R8: function mask holds requests until a rescan
      fn_mask = 1;
      tbl_wr(0, 3, 0);
      tbl_wr(1, 3, 0);
      tbl_wr(3, 3, 0);
      req(3); req(1); req(0);
      idle(3);
      pnd_rd(0, d);     chk(d == 32'hB, "R3 function mask holds requests", 96'(d), 96'hB);
      fn_mask = 0;
      idle(6);
      pnd_rd(0, d);     chk(d == 32'hB, "R9 mask drop alone sends nothing", 96'(d), 96'hB);
      expect_msg(0); expect_msg(1); expect_msg(3);
      rescan = 1; idle(1); rescan = 0;
      drain("R8 rescan drains in order");
      pnd_rd(0, d);     chk(d == 0, "R8 pending cleared after rescan", 96'(d), 0);

      // R10: pending dword beyond the implemented vectors reads zero; bit placement
      tbl_wr(6, 3, 32'h1);
      req(6);
      idle(2);
      pnd_rd(0, d);     chk(d == 32'h40, "R10 bit v of dword 0", 96'(d), 96'h40);
      pnd_rd(1, d);     chk(d == 0, "R10 padding dword zero", 96'(d), 0);
      expect_msg(6);
      tbl_wr(6, 3, 0);
      drain("R10 flush vector 6");

      // R11: stall keeps the message steady; blocked request is recorded
      msg_ready = 0;
      req(0);
      req(1);
      idle(2);
      chk(msg_valid && msg_addr == ent_addr(0) && msg_data == ent_data(0),
          "R11 held message", {msg_addr, msg_data}, {ent_addr(0), ent_data(0)});
      pnd_rd(0, d);     chk(d == 32'h2, "R11 blocked request pending", 96'(d), 2);
      idle(3);
      chk(msg_valid && msg_addr == ent_addr(0), "R11 still held",
          96'(msg_addr), 96'(ent_addr(0)));
      expect_msg(0); expect_msg(1);
      msg_ready = 1;
      drain("R11 release order");

      // R12: replay and fresh request meet in the same cycle
      tbl_wr(5, 3, 0);
      req(4);
      idle(2);
      expect_msg(4); expect_msg(5);
      tbl_wr(4, 3, 0);
      req(5);
      drain("R12 replay before fresh request");
      pnd_rd(0, d);     chk(d == 0, "R12 nothing left pending", 96'(d), 0);

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule